// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block takes an external SDRAM from power-up to a usable state before normal traffic reaches it. Software programs a mode word, an inter-command wait and a cycle budget through a four-entry register port. It then sets the enable bit of the control word. The hardware runs a fixed script on the SDRAM command pins: an enable slot, precharge-all, two auto-refreshes and a load-mode-register command. Each command lasts one cycle and is followed by the programmed number of NOP cycles.

When the last wait has elapsed, the block raises `init_ready` and releases the pins to the deselect state. If the whole script takes more cycles than the programmed refresh-interval budget, `init_error` is raised. Software can abort a running script, or drop ready, by writing the control word with the enable bit clear. A write that requests a command while the script is running is dropped and recorded in a sticky overrun bit.

Top module: `sdram_boot_seq`

## Requirements
- R1: After a synchronous active-high reset, the four command pins read 1111 (deselect, as {cs_n,ras_n,cas_n,we_n}), `init_ready` and `init_error` are 0, and the register reads are: address 0 = 0, address 2 = WAIT_RST, address 3 = BUDGET_RST.
- R2: A write to address 0 with bit 15 set while idle starts the script. The command slots then come in a fixed order, beginning in the cycle after the write edge: enable slot (0111), precharge-all (0010), refresh (0001), refresh (0001), load mode (0000), coded as {cs_n,ras_n,cas_n,we_n}.
- R3: Each command slot lasts one cycle and is followed by exactly W cycles of NOP (0111), where W is the value at address 2. With W = 0 the commands run back to back.
- R4: The precharge slot drives address bit 10 high. The load-mode slot drives the address-1 mode word on the address bus with bank 0. All other slots, including NOP, drive address 0 and bank 0.
- R5: `init_ready` rises in cycle 5(W+1)+1 after the start write edge, with the pins back at deselect. It stays high until reset or until enable is cleared.
- R6: A write to address 0 with bits 15, 14, 13 and 11 all clear aborts a running script or drops ready. The pins go to deselect and busy and ready read 0 from the next cycle.
- R7: A write to address 0 with any of bits 14, 13 or 11 set while the script runs is ignored, so the command timing is unchanged. It sets the sticky overrun bit (address 0, bit 2), which the next start clears.
- R8: `init_error` and address 0 bit 3 become 1 exactly when 5(W+1) exceeds the budget at address 3. They stay set until the next start.
- R9: Address 0 reads enable at bit 15, error at bit 3, overrun at bit 2, ready at bit 1 and busy at bit 0. Addresses 1, 2 and 3 read back the mode word, the wait and the budget, zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, combinational on reg_addr |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BA_W | Bank address |
| sd_addr | output | ROW_W | Address bus |
| init_ready | output | 1 | Initialization complete |
| init_error | output | 1 | Budget exceeded before completion |

## Verification
The bench uses the default parameters: 13 address bits, an 8-bit wait field resetting to 50 and a 16-bit budget resetting to 1000. These make reachable the full default script of 255 busy cycles, the zero-wait case where commands run back to back, and small random waits. The budget can be set exactly at the script length and one cycle below it, and the budget register is wide enough to hold both values. The mode field covers bit 10, so a random mode word can be told apart from the precharge address pattern.

// File: rtl/sdram_boot_pkg.sv
package sdram_boot_pkg;

    localparam int CTL_W      = 16;
    localparam int BIT_EN     = 15;
    localparam int BIT_PRE    = 14;
    localparam int BIT_LMR    = 13;
    localparam int BIT_REF    = 11;
    localparam int NUM_STEPS  = 5;

    typedef enum logic [2:0] {
        STEP_EN   = 3'd0,
        STEP_PRE  = 3'd1,
        STEP_REF1 = 3'd2,
        STEP_REF2 = 3'd3,
        STEP_LMR  = 3'd4
    } step_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_CMD  = 2'd1,
        PH_WAIT = 2'd2,
        PH_DONE = 2'd3
    } phase_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } pins_t;

    localparam pins_t PINS_DESEL = '{1'b1, 1'b1, 1'b1, 1'b1};
    localparam pins_t PINS_NOP   = '{1'b0, 1'b1, 1'b1, 1'b1};

    function automatic pins_t pins_of(step_e s);
        case (s)
            STEP_PRE:            return '{1'b0, 1'b0, 1'b1, 1'b0};
            STEP_REF1, STEP_REF2: return '{1'b0, 1'b0, 1'b0, 1'b1};
            STEP_LMR:            return '{1'b0, 1'b0, 1'b0, 1'b0};
            default:             return PINS_NOP;
        endcase
    endfunction

    function automatic logic has_cmd_bits(logic [CTL_W-1:0] w);
        return w[BIT_PRE] | w[BIT_LMR] | w[BIT_REF];
    endfunction

endpackage

// File: rtl/sdram_boot_regs.sv
module sdram_boot_regs
    import sdram_boot_pkg::*;
#(
    parameter int ROW_W      = 13,
    parameter int WAIT_W     = 8,
    parameter int BUDGET_W   = 16,
    parameter int WAIT_RST   = 50,
    parameter int BUDGET_RST = 1000
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr,
    input  logic [1:0]          addr,
    input  logic [CTL_W-1:0]    wdata,
    output logic [CTL_W-1:0]    rdata,
    input  logic                busy,
    input  logic                ready,
    input  logic                err,
    output logic                start,
    output logic                stop,
    output logic [ROW_W-1:0]    mode_q,
    output logic [WAIT_W-1:0]   wait_q,
    output logic [BUDGET_W-1:0] budget_q
);
    logic en_q, ovr_q;
    logic ctl_wr, blocked;

    assign ctl_wr  = wr && (addr == 2'd0);
    assign blocked = ctl_wr && busy && has_cmd_bits(wdata);
    assign start   = ctl_wr && !blocked && wdata[BIT_EN] && !busy && !ready;
    assign stop    = ctl_wr && !blocked && !wdata[BIT_EN];

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q     <= 1'b0;
            ovr_q    <= 1'b0;
            mode_q   <= '0;
            wait_q   <= WAIT_W'(WAIT_RST);
            budget_q <= BUDGET_W'(BUDGET_RST);
        end else begin
            if (blocked)    ovr_q <= 1'b1;
            else if (start) ovr_q <= 1'b0;
            if (start)      en_q  <= 1'b1;
            else if (stop)  en_q  <= 1'b0;
            if (wr && addr == 2'd1) mode_q   <= wdata[ROW_W-1:0];
            if (wr && addr == 2'd2) wait_q   <= wdata[WAIT_W-1:0];
            if (wr && addr == 2'd3) budget_q <= wdata[BUDGET_W-1:0];
        end
    end

    always_comb begin
        case (addr)
            2'd0:    rdata = {en_q, 11'd0, err, ovr_q, ready, busy};
            2'd1:    rdata = CTL_W'(mode_q);
            2'd2:    rdata = CTL_W'(wait_q);
            default: rdata = CTL_W'(budget_q);
        endcase
    end

    // R7: a command request while busy leaves the overrun flag set
    a_r7_overrun_sticky: assert property (@(posedge clk) disable iff (rst)
        blocked |=> ovr_q);
    // R7: a blocked write never aborts nor restarts
    a_r7_blocked_no_effect: assert property (@(posedge clk) disable iff (rst)
        blocked |-> !start && !stop);

endmodule

// File: rtl/sdram_boot_budget.sv
module sdram_boot_budget #(
    parameter int BUDGET_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic                busy,
    input  logic [BUDGET_W-1:0] budget,
    output logic                err
);
    localparam int CNT_W = BUDGET_W + 1;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] elapsed;

    always_ff @(posedge clk) begin
        if (rst) begin
            elapsed <= '0;
            err     <= 1'b0;
        end else if (start) begin
            elapsed <= '0;
            err     <= 1'b0;
        end else if (busy) begin
            if (elapsed >= CNT_W'(budget)) err <= 1'b1;
            if (elapsed != CNT_MAX) elapsed <= elapsed + CNT_W'(1);
        end
    end

    // R8: error stays until the next start
    a_r8_err_sticky: assert property (@(posedge clk) disable iff (rst)
        err && !start |=> err);
    // R8: a start clears the error
    a_r8_start_clears: assert property (@(posedge clk) disable iff (rst)
        start |=> !err);

endmodule

// File: rtl/sdram_boot_fsm.sv
module sdram_boot_fsm
    import sdram_boot_pkg::*;
#(
    parameter int ROW_W  = 13,
    parameter int BA_W   = 2,
    parameter int WAIT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              stop,
    input  logic [WAIT_W-1:0] wait_cyc,
    input  logic [ROW_W-1:0]  mode_word,
    output pins_t             pins,
    output logic [BA_W-1:0]   ba,
    output logic [ROW_W-1:0]  row_addr,
    output logic              busy,
    output logic              ready
);
    phase_e            phase;
    step_e             step;
    logic [WAIT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || stop) begin
            phase <= PH_IDLE;
            step  <= STEP_EN;
            cnt   <= '0;
        end else begin
            case (phase)
                PH_IDLE: if (start) begin
                    phase <= PH_CMD;
                    step  <= STEP_EN;
                end
                PH_CMD: if (wait_cyc != '0) begin
                    phase <= PH_WAIT;
                    cnt   <= wait_cyc - WAIT_W'(1);
                end else if (step == STEP_LMR) begin
                    phase <= PH_DONE;
                end else begin
                    step  <= step_e'(3'(step) + 3'd1);
                end
                PH_WAIT: if (cnt != '0) begin
                    cnt <= cnt - WAIT_W'(1);
                end else if (step == STEP_LMR) begin
                    phase <= PH_DONE;
                end else begin
                    phase <= PH_CMD;
                    step  <= step_e'(3'(step) + 3'd1);
                end
                default: ;
            endcase
        end
    end

    assign busy  = (phase == PH_CMD) || (phase == PH_WAIT);
    assign ready = (phase == PH_DONE);
    assign ba    = '0;

    always_comb begin
        pins     = PINS_DESEL;
        row_addr = '0;
        if (phase == PH_WAIT) begin
            pins = PINS_NOP;
        end else if (phase == PH_CMD) begin
            pins = pins_of(step);
            if (step == STEP_PRE) row_addr[10] = 1'b1;
            if (step == STEP_LMR) row_addr = mode_word;
        end
    end

    // R3: the wait counter steps down by one each waiting cycle
    a_r3_wait_countdown: assert property (@(posedge clk) disable iff (rst)
        phase == PH_WAIT && cnt != '0 && !stop |=> phase == PH_WAIT && cnt == $past(cnt) - WAIT_W'(1));
    // R5: ready holds until enable is cleared
    a_r5_ready_holds: assert property (@(posedge clk) disable iff (rst)
        ready && !stop |=> ready);
    // R6: an abort returns the pins to deselect
    a_r6_abort_deselect: assert property (@(posedge clk) disable iff (rst)
        stop |=> pins == PINS_DESEL && !busy && !ready);
    // R4: a precharge slot always carries address bit 10
    a_r4_precharge_a10: assert property (@(posedge clk) disable iff (rst)
        !pins.cs_n && !pins.ras_n && pins.cas_n && !pins.we_n |-> row_addr[10]);
    // R2: the script only leaves idle on a start
    a_r2_idle_until_start: assert property (@(posedge clk) disable iff (rst)
        phase == PH_IDLE && !start |=> phase == PH_IDLE);

endmodule

// File: rtl/sdram_boot_seq.sv
module sdram_boot_seq
    import sdram_boot_pkg::*;
#(
    parameter int ROW_W      = 13,
    parameter int BA_W       = 2,
    parameter int WAIT_W     = 8,
    parameter int BUDGET_W   = 16,
    parameter int WAIT_RST   = 50,
    parameter int BUDGET_RST = 1000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr,
    input  logic [1:0]       reg_addr,
    input  logic [15:0]      reg_wdata,
    output logic [15:0]      reg_rdata,
    output logic             sd_cs_n,
    output logic             sd_ras_n,
    output logic             sd_cas_n,
    output logic             sd_we_n,
    output logic [BA_W-1:0]  sd_ba,
    output logic [ROW_W-1:0] sd_addr,
    output logic             init_ready,
    output logic             init_error
);
    logic                start, stop, busy;
    logic [ROW_W-1:0]    mode_q;
    logic [WAIT_W-1:0]   wait_q;
    logic [BUDGET_W-1:0] budget_q;
    pins_t               pins;

    sdram_boot_regs #(
        .ROW_W(ROW_W), .WAIT_W(WAIT_W), .BUDGET_W(BUDGET_W),
        .WAIT_RST(WAIT_RST), .BUDGET_RST(BUDGET_RST)
    ) regs_i (
        .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata),
        .busy(busy), .ready(init_ready), .err(init_error),
        .start(start), .stop(stop),
        .mode_q(mode_q), .wait_q(wait_q), .budget_q(budget_q)
    );

    sdram_boot_fsm #(
        .ROW_W(ROW_W), .BA_W(BA_W), .WAIT_W(WAIT_W)
    ) fsm_i (
        .clk(clk), .rst(rst), .start(start), .stop(stop),
        .wait_cyc(wait_q), .mode_word(mode_q),
        .pins(pins), .ba(sd_ba), .row_addr(sd_addr),
        .busy(busy), .ready(init_ready)
    );

    sdram_boot_budget #(
        .BUDGET_W(BUDGET_W)
    ) budget_i (
        .clk(clk), .rst(rst), .start(start), .busy(busy),
        .budget(budget_q), .err(init_error)
    );

    assign sd_cs_n  = pins.cs_n;
    assign sd_ras_n = pins.ras_n;
    assign sd_cas_n = pins.cas_n;
    assign sd_we_n  = pins.we_n;

    // R1: outside the script the command pins are deselected
    a_r1_deselect_when_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy |-> sd_cs_n && sd_ras_n && sd_cas_n && sd_we_n);
    // R4: bank address stays zero through the load-mode slot
    a_r4_lmr_bank0: assert property (@(posedge clk) disable iff (rst)
        !sd_cs_n && !sd_ras_n && !sd_cas_n && !sd_we_n |-> sd_ba == '0 && sd_addr == mode_q);

endmodule

// File: tb/sdram_boot_seq_tb_top.sv
module sdram_boot_seq_tb_top;
    localparam int ROW_W = 13;
    localparam int BA_W  = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic reg_wr = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [15:0] reg_wdata = 16'd0;
    logic [15:0] reg_rdata;
    logic sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
    logic [BA_W-1:0] sd_ba;
    logic [ROW_W-1:0] sd_addr;
    logic init_ready, init_error;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    sdram_boot_seq dut_i (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
        .sd_ba(sd_ba), .sd_addr(sd_addr), .init_ready(init_ready), .init_error(init_error)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // expected {ready, pins[3:0], ba, addr} for cycle j after the start edge
    function automatic logic [31:0] exp_bus(int j, int w, logic [ROW_W-1:0] mode);
        int t = 5 * (w + 1);
        int stp, off;
        logic [3:0] p;
        logic [ROW_W-1:0] a;
        a = '0;
        if (j > t) return {16'd0, 1'b1, 4'b1111, 2'b00, 13'd0};
        stp = (j - 1) / (w + 1);
        off = (j - 1) % (w + 1);
        p = 4'b0111;
        if (off == 0) begin
            case (stp)
                1: begin p = 4'b0010; a[10] = 1'b1; end
                2, 3: p = 4'b0001;
                4: begin p = 4'b0000; a = mode; end
                default: p = 4'b0111;
            endcase
        end
        return {16'd0, 1'b0, p, 2'b00, a};
    endfunction

    function automatic logic [31:0] act_bus();
        return {16'd0, init_ready, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_ba, sd_addr};
    endfunction

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = 2'd0;
    endtask

    task automatic rd_chk(input string req, input logic [1:0] a, input logic [15:0] exp);
        @(negedge clk);
        reg_addr = a;
        #1;
        chk(req, {16'd0, reg_rdata}, {16'd0, exp});
        reg_addr = 2'd0;
    endtask

    // program, start, and follow the script cycle by cycle
    task automatic run_seq(input int w, input logic [ROW_W-1:0] mode, input int budget,
                           input int inj, input logic [15:0] inj_word);
        int t = 5 * (w + 1);
        logic err_exp;
        wr(2'd2, 16'(w));
        wr(2'd1, 16'(mode));
        wr(2'd3, 16'(budget));
        wr(2'd0, 16'h0000);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 16'h8000;
        err_exp = (t > budget);
        for (int j = 1; j <= t + 2; j++) begin
            @(negedge clk);
            reg_wr = 1'b0; reg_addr = 2'd0;
            // R2 R3 R4 R5 R7: command timing, untouched by a blocked request
            chk("R2/R3/R4/R5/R7 bus", act_bus(), exp_bus(j, w, mode));
            if (j == t + 1) begin
                #1;
                chk("R8 init_error", {31'd0, init_error}, {31'd0, err_exp});
                chk("R9 status word", {16'd0, reg_rdata},
                    {16'd0, 1'b1, 11'd0, err_exp, (inj != 0), 1'b1, 1'b0});
            end
            if (j == inj) begin
                reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = inj_word;
            end
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc >= 150000) begin
                errors++;
                $display("FAIL watchdog: actual %0d expected below 150000", cyc);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk("R1 pins", {28'd0, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 32'hF);
        chk("R1 ready/error", {30'd0, init_ready, init_error}, 32'd0);
        rd_chk("R1 status", 2'd0, 16'h0000);
        rd_chk("R1 wait reset", 2'd2, 16'd50);
        rd_chk("R1 budget reset", 2'd3, 16'd1000);

        // R9: mode readback
        wr(2'd1, 16'h1ABC);
        rd_chk("R9 mode readback", 2'd1, 16'h1ABC);

        // R3: zero wait, commands back to back
        run_seq(0, 13'h0123, 1000, 0, 16'h0);
        // R5 R8: default wait, budget exactly the script length then one short
        run_seq(50, 13'h0033, 255, 0, 16'h0);
        run_seq(2, 13'h1400, 14, 0, 16'h0);
        // R7: blocked requests of each kind
        run_seq(3, 13'h0555, 1000, 2, 16'hC000);
        run_seq(1, 13'h0001, 1000, 7, 16'h8800);
        run_seq(4, 13'h1FFF, 1000, 20, 16'hA000);

        // random mix
        for (int k = 0; k < 8; k++) begin
            int w = int'($urandom_range(0, 6));
            int t = 5 * (w + 1);
            int bud = t + int'($urandom_range(0, 2)) - 1;
            int inj = (($urandom_range(0, 1)) == 1) ? int'($urandom_range(1, t)) : 0;
            logic [15:0] iw = ($urandom_range(0, 1) == 1) ? 16'h8800 : 16'h2000;
            run_seq(w, 13'($urandom), bud, inj, iw);
        end

        // R5: ready holds
        repeat (5) @(negedge clk);
        chk("R5 ready holds", {31'd0, init_ready}, 32'd1);

        // R6: abort a running script
        wr(2'd2, 16'd3);
        wr(2'd0, 16'h0000);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 16'h8000;
        for (int j = 1; j <= 4; j++) begin
            @(negedge clk);
            reg_wr = 1'b0;
            chk("R6 pre-abort bus", act_bus(), exp_bus(j, 3, 13'h0));
        end
        reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 16'h0000;
        for (int j = 0; j < 25; j++) begin
            @(negedge clk);
            reg_wr = 1'b0;
            chk("R6 after abort", act_bus(), {16'd0, 1'b0, 4'b1111, 15'd0});
        end
        rd_chk("R6 status after abort", 2'd0, 16'h0000);

        // R6: clearing enable drops ready
        run_seq(0, 13'h0042, 1000, 0, 16'h0);
        wr(2'd0, 16'h0000);
        chk("R6 ready dropped", {31'd0, init_ready}, 32'd0);
        // R7: overrun cleared by a fresh start
        run_seq(1, 13'h0042, 1000, 0, 16'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule